// File: doc/BRIEF.md
# Conversion Result Queue with Sticky Error Flags

This block sits between an analog-to-digital converter and a host register interface. Each finished conversion delivers a data word, and the block stores it in a small first-in first-out queue. Host software polls an 8-bit status register and pulls one result from the queue data register for each poll that shows data waiting.

Two fault conditions are latched next to the queue. A result lost because the queue was full raises an overflow flag. A conversion start that arrives while the previous conversion has not yet finished raises an overrun flag. Both flags hold until software writes the clear register. That write also empties the queue and forgets any conversion in flight.

The queue depth, the data width, the status width and the way status is presented are all parameters. Status can be a registered snapshot taken on the read strobe, or a combinational value gated by that strobe.

Top module: `adc_result_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 16) results and returns them in arrival order. A `fifo_rd_i` pulse on a non-empty queue places the oldest result on `fifo_rdata_o` after the next rising clock edge.
- R2: Status bit 0 (data available) is 1 exactly when the queue holds at least one result.
- R3: A `conv_done_i` pulse on a full queue with no read in the same cycle discards the new word, keeps the stored results unchanged and sets status bit 1 (overflow).
- R4: A `conv_start_i` pulse while a conversion is in progress, with no `conv_done_i` in the same cycle, sets status bit 2 (overrun). A conversion is in progress from a start until the next done.
- R5: A `clear_i` pulse clears both error flags, empties the queue and ends any conversion in progress. `clear_i` takes priority over every other input in the same cycle.
- R6: The error flags stay set after the queue drains and after any number of status reads, until `clear_i`.
- R7: A `fifo_rd_i` pulse on an empty queue leaves `fifo_rdata_o` and the queue contents unchanged.
- R8: A done and a read in the same cycle on a full queue serve the read first and store the new word, with no overflow.
- R9: With the default registered status, a `stat_rd_i` pulse loads `status_o` after the next edge with {zeros in bits 7..3, overrun, overflow, data available} as they stood before that edge. Reading status never changes the flags.
- R10: A start and a done in the same cycle count as the old conversion ending and a new one beginning. This does not set overrun, and the block stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | One-cycle pulse when a conversion begins |
| conv_done_i | input | 1 | One-cycle pulse when a conversion result is ready |
| conv_data_i | input | DATA_W | Result word, valid with `conv_done_i` |
| fifo_rd_i | input | 1 | Queue data register read strobe |
| stat_rd_i | input | 1 | Status register read strobe |
| clear_i | input | 1 | Clear register write strobe |
| fifo_rdata_o | output | DATA_W | Last result read from the queue |
| status_o | output | STATUS_W | Status register read value |

## Verification
The properties assume that every strobe lasts one clock cycle and is sampled at the rising edge, and that `conv_data_i` is meaningful only while `conv_done_i` is high. They make no assumption about how strobes are spaced, so full-queue and busy-converter collisions are checked whenever they occur. The stimulus changes inputs only on the falling edge and holds each strobe for exactly one cycle. It sweeps every fill level from empty to full and creates each collision (full with done, full with done and read, start while busy, start with done) on purpose.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
   // Status register bit positions decoded by host software
   localparam int unsigned STAT_AVAIL_BIT = 0;
   localparam int unsigned STAT_OVF_BIT   = 1;
   localparam int unsigned STAT_OVR_BIT   = 2;
   localparam int unsigned STAT_MIN_W     = 3;

   typedef struct packed {
      logic ovr;
      logic ovf;
      logic avail;
   } adcq_flags_t;
endpackage

// File: rtl/adcq_store.sv
module adcq_store #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned LVL_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [LVL_W-1:0]  level_o,
   output logic              drop_o
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [LVL_W-1:0]  lvl_q;
   logic              full_w, empty_w, rd_go, wr_go;

   assign full_w  = (lvl_q == LVL_W'(DEPTH));
   assign empty_w = (lvl_q == '0);
   // read served first, so a full queue can accept a write alongside a read
   assign rd_go   = rd_i && !empty_w && !flush_i;
   assign wr_go   = wr_i && !flush_i && (!full_w || rd_go);
   assign drop_o  = wr_i && !flush_i && full_w && !rd_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         lvl_q   <= '0;
         rdata_o <= '0;
      end else if (flush_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         lvl_q  <= '0;
      end else begin
         if (rd_go) begin
            rdata_o <= mem_q[rptr_q];
            rptr_q  <= rptr_q + 1'b1;
         end
         if (wr_go) wptr_q <= wptr_q + 1'b1;
         case ({wr_go, rd_go})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_go) mem_q[wptr_q] <= wdata_i;
   end

   assign level_o = lvl_q;
endmodule

// File: rtl/adcq_busy.sv
module adcq_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic start_i,
   input  logic done_i,
   output logic busy_o,
   output logic overrun_o
);
   // a start with a simultaneous done means the earlier conversion ended
   assign overrun_o = start_i && busy_o && !done_i && !flush_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_o <= 1'b0;
      else if (flush_i)  busy_o <= 1'b0;
      else if (start_i)  busy_o <= 1'b1;
      else if (done_i)   busy_o <= 1'b0;
   end
endmodule

// File: rtl/adcq_flags.sv
module adcq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic set_ovf_i,
   input  logic set_ovr_i,
   output logic ovf_o,
   output logic ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_o <= 1'b0;
         ovr_o <= 1'b0;
      end else if (clr_i) begin
         ovf_o <= 1'b0;
         ovr_o <= 1'b0;
      end else begin
         ovf_o <= ovf_o | set_ovf_i;
         ovr_o <= ovr_o | set_ovr_i;
      end
   end
endmodule

// File: rtl/adcq_status.sv
module adcq_status
   import adcq_pkg::*;
#(
   parameter int unsigned STATUS_W    = 8,
   parameter bit          STATUS_SNAP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_i,
   input  adcq_flags_t         flags_i,
   output logic [STATUS_W-1:0] status_o
);
   logic [STATUS_W-1:0] live;

   always_comb begin
      live                 = '0;
      live[STAT_AVAIL_BIT] = flags_i.avail;
      live[STAT_OVF_BIT]   = flags_i.ovf;
      live[STAT_OVR_BIT]   = flags_i.ovr;
   end

   generate
      if (STATUS_SNAP) begin : g_snap
         logic [STATUS_W-1:0] snap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    snap_q <= '0;
            else if (rd_i) snap_q <= live;
         end
         assign status_o = snap_q;
      end else begin : g_gated
         assign status_o = rd_i ? live : '0;
      end
   endgenerate
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
   import adcq_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned STATUS_W    = 8,
   parameter bit          STATUS_SNAP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_start_i,
   input  logic                conv_done_i,
   input  logic [DATA_W-1:0]   conv_data_i,
   input  logic                fifo_rd_i,
   input  logic                stat_rd_i,
   input  logic                clear_i,
   output logic [DATA_W-1:0]   fifo_rdata_o,
   output logic [STATUS_W-1:0] status_o
);
   localparam int unsigned LVL_W = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (STATUS_W < STAT_MIN_W) begin : g_bad_stat
         $error("STATUS_W too narrow for the flag bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [LVL_W-1:0] level;
   logic             drop, busy, overrun_evt, ovf, ovr;
   adcq_flags_t      flags;

   adcq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (clear_i),
      .wr_i    (conv_done_i),
      .wdata_i (conv_data_i),
      .rd_i    (fifo_rd_i),
      .rdata_o (fifo_rdata_o),
      .level_o (level),
      .drop_o  (drop)
   );

   adcq_busy u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (clear_i),
      .start_i   (conv_start_i),
      .done_i    (conv_done_i),
      .busy_o    (busy),
      .overrun_o (overrun_evt)
   );

   adcq_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clear_i),
      .set_ovf_i (drop),
      .set_ovr_i (overrun_evt),
      .ovf_o     (ovf),
      .ovr_o     (ovr)
   );

   assign flags.avail = (level != '0);
   assign flags.ovf   = ovf;
   assign flags.ovr   = ovr;

   adcq_status #(.STATUS_W(STATUS_W), .STATUS_SNAP(STATUS_SNAP)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_i     (stat_rd_i),
      .flags_i  (flags),
      .status_o (status_o)
   );
endmodule

// File: rtl/adcq_checker.sv
module adcq_checker #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_start_i,
   input logic              conv_done_i,
   input logic              fifo_rd_i,
   input logic              clear_i,
   input logic [DATA_W-1:0] fifo_rdata_o,
   input logic [LVL_W-1:0]  level,
   input logic              busy,
   input logic              ovf,
   input logic              ovr
);
   wire full_c = (level == LVL_W'(DEPTH));

   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   p_overflow_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && full_c && !fifo_rd_i && !clear_i) |=> (ovf && full_c));

   p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start_i && busy && !conv_done_i && !clear_i) |=> ovr);

   p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (!ovf && !ovr && !busy && level == '0));

   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clear_i) |=> ovf);

   p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clear_i) |=> ovr);

   p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rd_i && level == '0) |=> $stable(fifo_rdata_o));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && fifo_rd_i && full_c && !ovf && !clear_i) |=> (!ovf && full_c));

   p_start_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start_i && conv_done_i && !ovr && !clear_i) |=> (!ovr && busy));
endmodule

bind adc_result_fifo adcq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_start_i (conv_start_i),
   .conv_done_i  (conv_done_i),
   .fifo_rd_i    (fifo_rd_i),
   .clear_i      (clear_i),
   .fifo_rdata_o (fifo_rdata_o),
   .level        (level),
   .busy         (busy),
   .ovf          (ovf),
   .ovr          (ovr)
);

// File: tb/adc_result_fifo_tb.sv
`timescale 1ns/1ps
module adc_result_fifo_tb;
   localparam int DW = 12;
   localparam int DP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st = 1'b0, dn = 1'b0, rd = 1'b0, srd = 1'b0, clr = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] rdata;
   logic [7:0]    status;
   int            n_chk = 0, n_bad = 0;
   logic [DW-1:0] last_rd = '0;
   logic [7:0]    s;

   always #2 clk = ~clk;

   adc_result_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .conv_start_i(st), .conv_done_i(dn),
      .conv_data_i(din), .fifo_rd_i(rd), .stat_rd_i(srd), .clear_i(clr),
      .fifo_rdata_o(rdata), .status_o(status)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic a_st, input logic a_dn, input logic [DW-1:0] a_d,
                      input logic a_rd, input logic a_srd, input logic a_clr);
      st = a_st; dn = a_dn; din = a_d; rd = a_rd; srd = a_srd; clr = a_clr;
      @(negedge clk);
      st = 0; dn = 0; din = '0; rd = 0; srd = 0; clr = 0;
   endtask

   task automatic push(input logic [DW-1:0] d); cyc(0, 1, d, 0, 0, 0); endtask
   task automatic pop();  cyc(0, 0, '0, 1, 0, 0); endtask
   task automatic clear(); cyc(0, 0, '0, 0, 0, 1); endtask
   task automatic getst(output logic [7:0] v); cyc(0, 0, '0, 0, 1, 0); v = status; endtask

   function automatic logic [DW-1:0] val(input int n, input int i);
      return DW'((n * 37 + i * 5 + 3) % 4096);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: empty queue, zero read data
      getst(s); chk("R2 reset status", s, 8'h00);
      pop();    chk("R7 empty read after reset", rdata, '0);

      // sweep every fill level (status bits: 0 avail, 1 overflow, 2 overrun)
      for (int n = 0; n <= DP; n++) begin
         clear();
         for (int i = 0; i < n; i++) push(val(n, i));
         getst(s); chk("R2 avail after fill", s, (n > 0) ? 8'h01 : 8'h00);
         for (int i = 0; i < n; i++) begin
            pop(); chk("R1 order", rdata, val(n, i)); last_rd = val(n, i);
         end
         getst(s); chk("R2 avail after drain", s, 8'h00);
         pop();    chk("R7 empty read holds data", rdata, last_rd);
         getst(s); chk("R7 empty read keeps queue empty", s, 8'h00);
      end

      // overflow: seventeenth result lost
      clear();
      for (int i = 0; i <= DP; i++) push(val(99, i));
      getst(s); chk("R3 overflow flag", s, 8'h03);
      for (int i = 0; i < DP; i++) begin
         pop(); chk("R3 stored results kept", rdata, val(99, i)); last_rd = val(99, i);
      end
      getst(s); chk("R6 overflow sticky after drain", s, 8'h02);
      getst(s); chk("R6 status read does not clear", s, 8'h02);
      getst(s); chk("R9 repeated status read", s, 8'h02);
      clear();
      getst(s); chk("R5 clear drops overflow", s, 8'h00);

      // overrun
      cyc(1, 0, '0, 0, 0, 0);
      cyc(1, 0, '0, 0, 0, 0);
      getst(s); chk("R4 overrun flag", s, 8'h04);
      push(12'h5A5);
      getst(s); chk("R6 overrun sticky after done", s, 8'h05);
      clear();
      getst(s); chk("R5 clear drops overrun and data", s, 8'h00);
      pop();    chk("R5 queue empty after clear", rdata, last_rd);
      cyc(1, 0, '0, 0, 0, 0);
      clear();
      cyc(1, 0, '0, 0, 0, 0);
      getst(s); chk("R5 clear ends conversion", s, 8'h00);

      // clear wins over a same-cycle done
      clear();
      cyc(0, 1, 12'h111, 0, 0, 1);
      getst(s); chk("R5 clear priority over done", s, 8'h00);

      // start and done together
      clear();
      cyc(1, 0, '0, 0, 0, 0);
      cyc(1, 1, 12'h0AB, 0, 0, 0);
      getst(s); chk("R10 start with done no overrun", s, 8'h01);
      cyc(1, 0, '0, 0, 0, 0);
      getst(s); chk("R10 still busy after start with done", s, 8'h05);

      // full queue, done and read together
      clear();
      for (int i = 0; i < DP; i++) push(val(7, i));
      cyc(0, 1, 12'hFEE, 1, 0, 0);
      chk("R8 read served first", rdata, val(7, 0));
      getst(s); chk("R8 no overflow", s, 8'h01);
      for (int i = 1; i < DP; i++) begin
         pop(); chk("R8 remaining order", rdata, val(7, i));
      end
      pop();    chk("R8 new word stored", rdata, 12'hFEE);
      getst(s); chk("R8 drained clean", s, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule